// File: doc/BRIEF.md
# Phase-Interleaved Bitmap Video Fetcher

This block lets a processor and a raster video output share one byte-wide RAM without ever stalling the processor. Every processor clock period is split into two halves. In the low half the block takes the RAM, reads the next byte of a 320x200 frame buffer and latches it as the current pixel. In the high half it passes the processor's address, write strobe and write data straight through to the RAM and returns the read data to the processor.

The frame buffer fills the bottom 64000 bytes of one 64 KB bank of a 512 KB address space, chosen by a 3-bit bank selector. The selector is sampled only at the frame boundary, so a change never tears a picture. The block also keeps the raster position, drives horizontal and vertical sync, and pulls an active-low interrupt line low for the vertical sync lines. Totals, active sizes and sync positions are parameters.

Top module: `vid_fetch`

## Requirements
- R1: `phi2_o` is low in the first cycle after reset and toggles on every `clk` edge after that. The low half belongs to video and the high half belongs to the processor.
- R2: While `phi2_o` is high, `ram_addr_o`, `ram_we_o` and `ram_wdata_o` follow `cpu_addr_i`, `cpu_we_i` and `cpu_wdata_i`, `ram_cs_o` is 1, and `cpu_rdata_o` returns `ram_rdata_i`. A processor write is stored and can be read back in a later high half.
- R3: In a low half that falls inside the active area, `ram_cs_o` is 1, `ram_we_o` is 0 and `ram_addr_o` is `{bank, offset}`: the bank in bits 18..16 and the pixel offset in bits 15..0. The processor inputs have no effect on this address.
- R4: The pixel offset is 0 at the first pixel of each frame. It rises by one per active pixel in row-major order and reaches 63999 at the last pixel of line 199.
- R5: In a low half outside the active area, `ram_cs_o`, `ram_we_o` and `ram_addr_o` are all 0, and the pixel latched for that position is 0.
- R6: The byte read in a low half appears on `pix_o` after the edge that ends that half and is held until the next low half ends. The colour fields are `red_o` = bits 2..0, `green_o` = bits 5..3 and `blue_o` = bits 7..6.
- R7: The bank used for a frame is the value of `bank_i` at the last position of the previous frame. The first frame after reset uses bank 1. A change of `bank_i` during a frame has no effect on that frame's addresses.
- R8: `vsync_o` is 1 and `vint_n_o` is 0 on lines VS_START to VS_START+2 only, which is exactly 3 lines per frame.
- R9: `hsync_o` is 1 for horizontal positions HS_START to HS_START+HS_LEN-1 on every line.
- R10: During reset, `phi2_o`, `pix_o`, `hsync_o` and `vsync_o` are 0 and `vint_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the processor rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_i | input | 3 | Frame buffer bank selector |
| cpu_addr_i | input | 19 | Processor address |
| cpu_we_i | input | 1 | Processor write strobe |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rdata_o | output | 8 | Read data returned to the processor |
| ram_cs_o | output | 1 | RAM select |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | 19 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data |
| phi2_o | output | 1 | Processor clock phase |
| pix_o | output | 8 | Current pixel byte |
| red_o | output | 3 | Red field of the pixel |
| green_o | output | 3 | Green field of the pixel |
| blue_o | output | 2 | Blue field of the pixel |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| vint_n_o | output | 1 | Active-low vertical interrupt |

## Verification
A wrong raster or offset count shows as a wrong video address in the very next low half, because every fetch address is compared with a value the bench computes for that position. A wrong bank register stays hidden until the next frame boundary, so the bench changes the selector in the middle of a frame and then follows the following frame. A slipped phase or a wrong pixel latch shows within one processor cycle as a mismatch on `pix_o` or on the processor pass-through.

// File: rtl/vid_fetch.sv
module vid_fetch #(
  parameter int H_ACTIVE   = 320,
  parameter int H_TOTAL    = 328,
  parameter int HS_START   = 322,
  parameter int HS_LEN     = 4,
  parameter int V_ACTIVE   = 200,
  parameter int V_TOTAL    = 206,
  parameter int VS_START   = 202,
  parameter int VS_LINES   = 3,
  parameter int RESET_BANK = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bank_i,
  input  logic [18:0] cpu_addr_i,
  input  logic        cpu_we_i,
  input  logic [7:0]  cpu_wdata_i,
  output logic [7:0]  cpu_rdata_o,
  output logic        ram_cs_o,
  output logic        ram_we_o,
  output logic [18:0] ram_addr_o,
  output logic [7:0]  ram_wdata_o,
  input  logic [7:0]  ram_rdata_i,
  output logic        phi2_o,
  output logic [7:0]  pix_o,
  output logic [2:0]  red_o,
  output logic [2:0]  green_o,
  output logic [1:0]  blue_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        vint_n_o
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam int PIX_TOTAL = H_ACTIVE * V_ACTIVE;
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT  = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_ACT  = VW'(V_ACTIVE);
  localparam logic [HW-1:0] HS_B   = HW'(HS_START);
  localparam logic [HW-1:0] HS_E   = HW'(HS_START + HS_LEN);
  localparam logic [VW-1:0] VS_B   = VW'(VS_START);
  localparam logic [VW-1:0] VS_E   = VW'(VS_START + VS_LINES);

  logic          ph;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [15:0]   offset;
  logic [2:0]    bank_q;
  logic [7:0]    pix_q;

  wire act  = (hcnt < H_ACT) && (vcnt < V_ACT);
  wire eol  = (hcnt == H_LAST);
  wire eof  = eol && (vcnt == V_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= 1'b0;
      hcnt   <= '0;
      vcnt   <= '0;
      offset <= '0;
      bank_q <= 3'(RESET_BANK);
      pix_q  <= '0;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        pix_q <= act ? ram_rdata_i : 8'h00;
        hcnt  <= eol ? '0 : hcnt + 1'b1;
        if (eol) vcnt <= eof ? '0 : vcnt + 1'b1;
        if (eof) begin
          offset <= '0;
          bank_q <= bank_i;
        end else if (act) begin
          offset <= offset + 16'd1;
        end
      end
    end
  end

  assign phi2_o      = ph;
  assign ram_cs_o    = ph | act;
  assign ram_we_o    = ph & cpu_we_i;
  assign ram_addr_o  = ph ? cpu_addr_i : (act ? {bank_q, offset} : 19'd0);
  assign ram_wdata_o = ph ? cpu_wdata_i : 8'h00;
  assign cpu_rdata_o = ph ? ram_rdata_i : 8'h00;

  assign pix_o   = pix_q;
  assign red_o   = pix_q[2:0];
  assign green_o = pix_q[5:3];
  assign blue_o  = pix_q[7:6];

  assign hsync_o  = (hcnt >= HS_B) && (hcnt < HS_E);
  assign vsync_o  = (vcnt >= VS_B) && (vcnt < VS_E);
  assign vint_n_o = ~vsync_o;

  // R1
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph != $past(ph)));
  // R4
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (offset < 16'(PIX_TOTAL)));
  // R4
  offset_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == '0 && vcnt == '0) |-> (offset == 16'd0));
  // R5
  blank_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph && !$past(act)) |-> (pix_q == 8'h00));
  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> (hcnt == '0 && vcnt == '0));
  // R8
  vint_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vint_n_o) |-> (hcnt == '0 && vcnt == VS_B));
endmodule

// File: tb/test_vid_fetch.sv
module test_vid_fetch;
  localparam int HA = 320, HT = 328, VA = 200, VT = 206;
  localparam int HSB = 322, HSE = 326, VSB = 202, VSE = 205;

  typedef struct packed {
    logic [1:0]  fr;
    logic [8:0]  h;
    logic [7:0]  v;
    logic        act;
    logic [18:0] addr;
    logic [7:0]  pix;
  } slot_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bank_i;
  logic [18:0] cpu_addr_i;
  logic cpu_we_i;
  logic [7:0] cpu_wdata_i, cpu_rdata_o, ram_wdata_o, ram_rdata_i, pix_o;
  logic ram_cs_o, ram_we_o, phi2_o, hsync_o, vsync_o, vint_n_o;
  logic [18:0] ram_addr_o;
  logic [2:0] red_o, green_o;
  logic [1:0] blue_o;

  always #2.5 clk = ~clk;

  vid_fetch i_vid_fetch (
    .clk(clk), .rst_n(rst_n), .bank_i(bank_i),
    .cpu_addr_i(cpu_addr_i), .cpu_we_i(cpu_we_i), .cpu_wdata_i(cpu_wdata_i),
    .cpu_rdata_o(cpu_rdata_o), .ram_cs_o(ram_cs_o), .ram_we_o(ram_we_o),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
    .phi2_o(phi2_o), .pix_o(pix_o), .red_o(red_o), .green_o(green_o),
    .blue_o(blue_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .vint_n_o(vint_n_o)
  );

  int checks = 0, fails = 0;
  slot_t q[$];
  logic [7:0] smem [16];
  int vint_lines = 0;
  int k = 0;
  logic rd_pend = 1'b0;
  logic [7:0] rd_exp;
  logic prev_ph = 1'b1;
  logic wd_hit = 1'b0;
  int wd = 0;

  function automatic logic [7:0] pat(input logic [18:0] a);
    return (a[7:0] + 8'(a[15:8] * 3)) ^ {a[18:16], 5'b10101};
  endfunction

  always_comb begin
    if (ram_addr_o[18:4] == 15'h0040) ram_rdata_i = smem[ram_addr_o[3:0]];
    else ram_rdata_i = pat(ram_addr_o);
  end

  always @(posedge clk)
    if (ram_we_o && ram_addr_o[18:4] == 15'h0040) smem[ram_addr_o[3:0]] <= ram_wdata_o;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_frame(input int fr, input logic [2:0] bk, input int nl);
    int off = 0;
    for (int v = 0; v < nl; v++)
      for (int h = 0; h < HT; h++) begin
        slot_t s;
        s.fr   = 2'(fr);
        s.h    = 9'(h);
        s.v    = 8'(v);
        s.act  = (h < HA) && (v < VA);
        s.addr = s.act ? {bk, 16'(off)} : 19'd0;
        s.pix  = s.act ? pat(s.addr) : 8'h00;
        if (s.act) off++;
        q.push_back(s);
      end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 180000 && !wd_hit) wd_hit = 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && q.size() != 0 && !wd_hit) begin
      slot_t cur;
      chk(phi2_o != prev_ph, "R1", "phase", phi2_o, !prev_ph);
      prev_ph = phi2_o;
      if (!phi2_o) begin
        cur = q[0];
        if (cur.act) begin
          chk(ram_cs_o == 1'b1, "R3", "cs", ram_cs_o, 1);
          chk(ram_addr_o == cur.addr, "R3", "video addr", ram_addr_o, cur.addr);
        end else begin
          chk(ram_cs_o == 1'b0, "R5", "cs blank", ram_cs_o, 0);
          chk(ram_addr_o == 19'd0, "R5", "addr blank", ram_addr_o, 0);
        end
        if (cur.act && cur.v == VA - 1 && cur.h == HA - 1)
          chk(ram_addr_o[15:0] == 16'd63999, "R4", "last offset", ram_addr_o[15:0], 63999);
        if (cur.h == 0 && cur.v == 0)
          chk(ram_addr_o[15:0] == 16'd0, "R4", "first offset", ram_addr_o[15:0], 0);
        chk(ram_we_o == 1'b0, "R3", "we in video half", ram_we_o, 0);
        chk(hsync_o == (cur.h >= HSB && cur.h < HSE), "R9", "hsync", hsync_o, cur.h >= HSB && cur.h < HSE);
        chk(vsync_o == (cur.v >= VSB && cur.v < VSE), "R8", "vsync", vsync_o, cur.v >= VSB && cur.v < VSE);
        chk(vint_n_o == !(cur.v >= VSB && cur.v < VSE), "R8", "vint_n", vint_n_o, !(cur.v >= VSB && cur.v < VSE));
        if (cur.fr == 0 && cur.h == 0 && !vint_n_o) vint_lines++;
        if (cur.fr == 0 && cur.v == 100 && cur.h == 0) bank_i = 3'd6;
        rd_pend    = k[0];
        cpu_we_i   = !k[0];
        cpu_addr_i = 19'h00400 + 19'((k / 2) % 16);
        cpu_wdata_i = 8'(k / 2) ^ 8'h5A;
        if (k[0]) rd_exp = 8'(k / 2) ^ 8'h5A;
        k++;
      end else begin
        cur = q.pop_front();
        chk(pix_o == cur.pix, cur.act ? "R6" : "R5", "pixel", pix_o, cur.pix);
        chk({blue_o, green_o, red_o} == pix_o && red_o == pix_o[2:0] && blue_o == pix_o[7:6],
            "R6", "colour fields", {blue_o, green_o, red_o}, pix_o);
        chk(ram_addr_o == cpu_addr_i && ram_cs_o && ram_we_o == cpu_we_i
            && ram_wdata_o == cpu_wdata_i, "R2", "cpu pass", ram_addr_o, cpu_addr_i);
        if (rd_pend) chk(cpu_rdata_o == rd_exp, "R2", "cpu readback", cpu_rdata_o, rd_exp);
      end
    end
  end

  initial begin
    bank_i = 3'd5;
    cpu_addr_i = '0;
    cpu_we_i = 1'b0;
    cpu_wdata_i = '0;
    for (int i = 0; i < 16; i++) smem[i] = 8'h00;
    // R7: frame 0 uses the reset bank 1; frame 1 the value present at the boundary (6)
    push_frame(0, 3'd1, VT);
    push_frame(1, 3'd6, 3);
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R10
    chk(phi2_o == 0 && pix_o == 0 && hsync_o == 0 && vsync_o == 0 && vint_n_o == 1,
        "R10", "reset state", {phi2_o, pix_o, hsync_o, vsync_o, vint_n_o}, 1);
    @(posedge clk);
    #1 rst_n = 1'b1;
    while (q.size() != 0 && !wd_hit) @(posedge clk);
    if (wd_hit) chk(1'b0, "watchdog", "timeout", wd, 180000);
    // R8
    chk(vint_lines == 3, "R8", "interrupt lines per frame", vint_lines, 3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule